// File: doc/BRIEF.md
# Packet-to-SPI Bridge Command Engine

This block turns one host command packet into one SPI master transaction and answers with one response packet. Commands arrive on a byte stream with valid, ready and last. The first byte gives the number of bytes to send, the second gives the number of bytes to fetch, and the bytes to send follow. The block checks both counts against the limit and against the packet length it actually received. If the command is sound, it pulls chip select low, sends the write bytes, and then clocks in the read bytes. Chip select stays low for the whole transfer.

The answer goes out on a second byte stream. It starts with a 16-bit status word, low byte first. On success the bytes fetched from the SPI target follow the status word. On any error the response is the status word alone. A busy input makes the block refuse a command when the shared resource is not available. A hold input lets the SPI side stall its clock. A watchdog starts when chip select falls and ends a transfer that takes too long.

Top module: `spi_cmd_bridge`

## Requirements
- R1: After reset the block accepts input (in_ready high), offers no response (out_valid low), keeps spi_cs_n high and spi_sclk low, and holds spi_mosi high.
- R2: A valid command produces a response of 2 + read-count bytes: status 0x0000 sent low byte first, then the read bytes in the order they were clocked in. out_last is high on the final byte only.
- R3: For a valid command with a nonzero total, spi_cs_n falls exactly once and stays low for the whole transfer. Each byte moves MSB first in SPI mode 0. The write bytes go out first, then one byte of 0xFF on MOSI for each read byte. MISO is sampled on the rising edge of SCLK.
- R4: If the write count (byte 0) is above 62, or differs from the number of bytes received after byte 1, the status is 0x0003 and chip select is never asserted.
- R5: If the write count is valid but the read count (byte 1) is above 62, the status is 0x0004 and no transfer takes place. When both counts are bad, the status is 0x0003.
- R6: If res_busy is high when a well-formed command ends, the status is 0x0002 and no transfer takes place.
- R7: If the transfer does not finish within TIMEOUT_CYC cycles after chip select falls (for example, while spi_hold stalls it), the status is 0x0001 and chip select is released.
- R8: A packet shorter than the two header bytes is an internal error. It returns status 0x8001: bit 15 set, internal code 1 in bits 14:0.
- R9: Every error response is exactly two bytes long.
- R10: A valid command with both counts zero returns status 0x0000 in two bytes without asserting chip select.
- R11: in_ready stays low from the end of a command until its response has been fully taken. While out_valid is high and out_ready is low, out_data and out_last hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Command byte valid |
| in_ready | output | 1 | Block accepts a command byte |
| in_data | input | 8 | Command byte |
| in_last | input | 1 | Final byte of the command packet |
| out_valid | output | 1 | Response byte valid |
| out_ready | input | 1 | Consumer takes the response byte |
| out_data | output | 8 | Response byte |
| out_last | output | 1 | Final byte of the response packet |
| res_busy | input | 1 | Shared resource unavailable |
| spi_hold | input | 1 | Stalls the SPI clock while high |
| spi_sclk | output | 1 | SPI clock, idle low |
| spi_mosi | output | 1 | SPI data to target |
| spi_miso | input | 1 | SPI data from target |
| spi_cs_n | output | 1 | SPI chip select, active low |

## Verification
The bench sends random commands with counts from 0 to 62 and checks them against a behavioural SPI target. Each target byte depends on its position in the transfer, so a read byte that is off by one position, or that was sampled on the wrong edge, shows up as a data mismatch. The MOSI bytes logged by the target show whether the write and fill phases came out in the right order and the right length. Directed packets then probe the edges of validation: counts of 62 and 63, a payload one byte short or one byte long, both counts bad at once, a header-only packet, a one-byte packet, busy asserted, and a clock held still until the watchdog fires. Together these show which of the five status codes wins and whether chip select ever moved.

// File: rtl/spi_cmd_bridge.sv
module spi_cmd_bridge #(
  parameter int MAX_XFER    = 62,
  parameter int CLK_DIV     = 2,
  parameter int TIMEOUT_CYC = 8192
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_last,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       out_last,
  input  logic       res_busy,
  input  logic       spi_hold,
  output logic       spi_sclk,
  output logic       spi_mosi,
  input  logic       spi_miso,
  output logic       spi_cs_n
);
  localparam int IW = $clog2(MAX_XFER);
  localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [7:0] MAXB = 8'(MAX_XFER);
  localparam logic [15:0] ST_OK = 16'h0000, ST_TMO = 16'h0001, ST_BUSY = 16'h0002,
                          ST_WCNT = 16'h0003, ST_RCNT = 16'h0004, ST_INT = 16'h8001;

  typedef enum logic [1:0] {S_RX, S_CHK, S_SPI, S_RSP} st_t;
  st_t st;

  logic [7:0]  wc, rc, cnt, xi, oi, olen, tx_sh, rx_sh;
  logic [15:0] status;
  logic [7:0]  mem [MAX_XFER];
  logic [2:0]  bit_n;
  logic [DW-1:0] div;
  logic [TW-1:0] tmo;
  logic sclk_q, cs_q;

  wire [7:0] total = wc + rc;
  wire [7:0] pidx  = cnt - 8'd2;
  wire [7:0] ridx  = xi - wc;
  wire [7:0] oidx  = oi - 8'd2;
  wire [7:0] nxt   = xi + 8'd1;
  wire       expire = (tmo == TW'(TIMEOUT_CYC - 1));
  wire       edge_t = (st == S_SPI) && !expire && !spi_hold && (div == DW'(CLK_DIV - 1));
  wire       byte_done = edge_t && sclk_q && (bit_n == 3'd7);
  wire       rx_wr = (st == S_RX) && in_valid && (cnt >= 8'd2) && (pidx < MAXB);
  wire       rd_wr = byte_done && (xi >= wc);
  wire [7:0] nxt_tx = (nxt < wc) ? mem[nxt[IW-1:0]] : 8'hFF;

  assign in_ready  = (st == S_RX);
  assign out_valid = (st == S_RSP);
  assign out_last  = out_valid && (oi == olen - 8'd1);
  assign out_data  = (oi == 8'd0) ? status[7:0] :
                     (oi == 8'd1) ? status[15:8] : mem[oidx[IW-1:0]];
  assign spi_sclk  = sclk_q;
  assign spi_cs_n  = cs_q;
  assign spi_mosi  = tx_sh[7];

  always_ff @(posedge clk) begin
    if (rx_wr)      mem[pidx[IW-1:0]] <= in_data;
    else if (rd_wr) mem[ridx[IW-1:0]] <= rx_sh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_RX; wc <= '0; rc <= '0; cnt <= '0; xi <= '0; oi <= '0; olen <= 8'd2;
      status <= ST_OK; tx_sh <= 8'hFF; rx_sh <= '0; bit_n <= '0; div <= '0; tmo <= '0;
      sclk_q <= 1'b0; cs_q <= 1'b1;
    end else begin
      case (st)
        S_RX: if (in_valid) begin
          if (cnt == 8'd0)      wc <= in_data;
          else if (cnt == 8'd1) rc <= in_data;
          if (cnt != 8'hFF) cnt <= cnt + 8'd1;
          if (in_last) st <= S_CHK;
        end
        S_CHK: begin
          cnt <= '0; oi <= '0; olen <= 8'd2; st <= S_RSP;
          if (cnt < 8'd2)                  status <= ST_INT;
          else if (wc > MAXB || wc != pidx) status <= ST_WCNT;
          else if (rc > MAXB)              status <= ST_RCNT;
          else if (res_busy)               status <= ST_BUSY;
          else begin
            status <= ST_OK;
            olen <= 8'd2 + rc;
            if (total != 8'd0) begin
              st <= S_SPI; cs_q <= 1'b0; xi <= '0; bit_n <= '0; div <= '0; tmo <= '0;
              tx_sh <= (wc != 8'd0) ? mem[0] : 8'hFF;
            end
          end
        end
        S_SPI: begin
          tmo <= tmo + TW'(1);
          if (expire) begin
            status <= ST_TMO; olen <= 8'd2; cs_q <= 1'b1; sclk_q <= 1'b0;
            tx_sh <= 8'hFF; st <= S_RSP;
          end else if (!spi_hold) begin
            if (!edge_t) div <= div + DW'(1);
            else begin
              div <= '0;
              if (!sclk_q) begin
                sclk_q <= 1'b1;
                rx_sh <= {rx_sh[6:0], spi_miso};
              end else begin
                sclk_q <= 1'b0;
                bit_n <= bit_n + 3'd1;
                if (byte_done) begin
                  if (nxt == total) begin
                    cs_q <= 1'b1; tx_sh <= 8'hFF; st <= S_RSP;
                  end else begin
                    xi <= nxt; tx_sh <= nxt_tx;
                  end
                end else tx_sh <= {tx_sh[6:0], 1'b1};
              end
            end
          end
        end
        S_RSP: if (out_ready) begin
          if (oi == olen - 8'd1) st <= S_RX;
          else oi <= oi + 8'd1;
        end
        default: st <= S_RX;
      endcase
    end
  end
endmodule

module spi_cmd_bridge_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_last,
  input logic       spi_cs_n,
  input logic       spi_sclk,
  input logic       spi_mosi
);
  p_cs_off_in_resp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> spi_cs_n);
  p_sclk_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);
  p_mosi_hold_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));
  p_no_accept_in_resp_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);
  p_resp_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));
endmodule

bind spi_cmd_bridge spi_cmd_bridge_chk u_chk (.*);

// File: tb/tb_spi_cmd_bridge.sv
module tb_spi_cmd_bridge;
  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic in_valid = 0, in_last = 0, out_ready = 0, res_busy = 0, spi_hold = 0, spi_miso = 0;
  logic [7:0] in_data = 0;
  logic in_ready, out_valid, out_last, spi_sclk, spi_mosi, spi_cs_n;
  logic [7:0] out_data;

  spi_cmd_bridge dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_last(in_last), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .res_busy(res_busy), .spi_hold(spi_hold), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n));

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [7:0] pkt [80];
  logic [7:0] rsp [80];
  logic [7:0] mlog [140];
  int plen, rlen, cs_falls, cap_n, cap_b, ob_bit, ob_byte;
  logic [7:0] cap, pseed = 0;

  function automatic logic [7:0] pat(int i);
    return 8'h3C ^ 8'(i * 29) ^ pseed;
  endfunction

  function automatic int exp_status(int n, int wc, int rc, bit busy, bit hold);
    if (n < 2) return 16'h8001;
    if (wc > 62 || wc != n - 2) return 3;
    if (rc > 62) return 4;
    if (busy) return 2;
    if (hold && (wc + rc) > 0) return 1;
    return 0;
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      summary();
    end
  end

  always @(negedge spi_cs_n) begin
    logic [7:0] b;
    cs_falls++; cap_n = 0; cap_b = 0; ob_bit = 0; ob_byte = 0;
    b = pat(0); spi_miso = b[7];
  end
  always @(posedge spi_sclk) if (!spi_cs_n) begin
    cap = {cap[6:0], spi_mosi}; cap_n++;
    if (cap_n == 8) begin
      if (cap_b < 140) mlog[cap_b] = cap;
      cap_b++; cap_n = 0;
    end
  end
  always @(negedge spi_sclk) if (!spi_cs_n) begin
    logic [7:0] b;
    ob_bit++;
    if (ob_bit == 8) begin ob_bit = 0; ob_byte++; end
    b = pat(ob_byte); spi_miso = b[7 - ob_bit];
  end

  task automatic run(int wc, int rc, int npay, bit busy, bit hold, bit short1);
    int st, elen, i;
    bit ok;
    pkt[0] = 8'(wc); pkt[1] = 8'(rc);
    for (int k = 0; k < npay; k++) pkt[2 + k] = 8'($urandom);
    plen = short1 ? 1 : 2 + npay;
    pseed = 8'($urandom);
    res_busy = busy; spi_hold = hold; cs_falls = 0; cap_b = 0;
    i = 0;
    while (i < plen) begin
      @(negedge clk);
      in_valid = 1; in_data = pkt[i]; in_last = (i == plen - 1);
      if (in_ready) i++;
    end
    @(negedge clk); in_valid = 0; in_last = 0;
    rlen = 0;
    forever begin
      @(negedge clk);
      out_ready = ($urandom % 4) != 0;
      if (out_valid && out_ready) begin
        if (rlen < 80) rsp[rlen] = out_data;
        rlen++;
        if (out_last) break;
      end
    end
    @(negedge clk); out_ready = 0; res_busy = 0; spi_hold = 0;
    st = exp_status(plen, wc, rc, busy, hold);
    elen = (st == 0) ? 2 + rc : 2;
    chk({rsp[1], rsp[0]} == 16'(st), (st == 0) ? "R2 status" : (st == 3) ? "R4 status" :
        (st == 4) ? "R5 status" : (st == 2) ? "R6 status" : (st == 1) ? "R7 status" : "R8 status",
        {rsp[1], rsp[0]}, st);
    chk(rlen == elen, (st == 0) ? "R2 length" : "R9 length", rlen, elen);
    if (st == 0 && rlen == elen) begin
      ok = 1;
      for (int j = 0; j < rc; j++) if (rsp[2 + j] != pat(wc + j)) ok = 0;
      chk(ok, "R2 read data", rc, rc);
      ok = (cap_b == wc + rc);
      for (int j = 0; j < wc + rc && ok; j++)
        if (mlog[j] != ((j < wc) ? pkt[2 + j] : 8'hFF)) ok = 0;
      chk(ok, "R3 mosi bytes", cap_b, wc + rc);
    end
    chk(cs_falls == ((st == 1 || (st == 0 && wc + rc > 0)) ? 1 : 0),
        (st == 0 && wc + rc == 0) ? "R10 cs count" : "R3 R4 R5 R6 cs count",
        cs_falls, (st == 1 || (st == 0 && wc + rc > 0)) ? 1 : 0);
    chk(spi_cs_n == 1 && in_ready == 1, "R7 R11 idle after response", spi_cs_n, 1);
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(in_ready == 1 && out_valid == 0, "R1 stream idle", {in_ready, out_valid}, 2'b10);
    chk(spi_cs_n == 1 && spi_sclk == 0 && spi_mosi == 1, "R1 spi idle",
        {spi_cs_n, spi_sclk, spi_mosi}, 3'b101);
    run(62, 62, 62, 0, 0, 0);
    run(1, 0, 1, 0, 0, 0);
    run(0, 1, 0, 0, 0, 0);
    run(0, 0, 0, 0, 0, 0);
    run(63, 5, 63, 0, 0, 0);
    run(10, 5, 9, 0, 0, 0);
    run(10, 5, 11, 0, 0, 0);
    run(4, 63, 4, 0, 0, 0);
    run(70, 70, 3, 0, 0, 0);
    run(3, 3, 3, 1, 0, 0);
    run(3, 3, 3, 0, 1, 0);
    run(2, 2, 0, 0, 0, 1);
    run(5, 7, 5, 0, 0, 0);
    for (int t = 0; t < 30; t++) begin
      int wc, rc, np;
      wc = $urandom % 63; rc = $urandom % 63; np = wc;
      if ($urandom % 6 == 0) np = $urandom % 63;
      run(wc, rc, np, ($urandom % 10) == 0, 0, 0);
    end
    summary();
  end
endmodule